// File: doc/BRIEF.md
# DRAM Address Multiplexer and Refresh Counter

This block turns a physical byte address into the multiplexed address for a DRAM array of up to eight sockets, each eight bytes wide. Every socket carries its own geometry code, which sets its row and column widths or marks it empty. Populated sockets are packed into one contiguous address range in socket-index order, so an empty socket can sit at any position without leaving a hole. The block picks the socket that holds the address and raises the matching RAS line. It then drives the row and, one cycle later, the column on a shared 12-bit memory address bus. A `row_phase` output says which of the two is on the bus.

After the row phase the block steps the column once per beat. A CPU burst has four beats and wraps within its 32-byte line. A PCI burst counts upward until the requester stops it or the column reaches the end of the DRAM page. A single-beat access ends after one beat. Accesses are not interleaved: every beat of an access stays in the socket chosen at the start.

A refresh request takes priority over an access. It places the refresh row counter on the same address lines, raises the RAS of every populated socket, and then advances the counter, which wraps to zero after its last value. Pulse timing, parity and the host bus protocol belong to the neighbouring blocks.

Top module: `dram_addr_mux`

## Requirements
- R1: Geometry codes per 4-bit socket field (socket i at bits 4i+3..4i): 1=10x9, 2=11x9, 3=12x9, 4=10x10, 5=11x10, 6=12x10, 7=11x11 (rows x columns), 8=mixed mode, 0 and 9..15=empty. A socket holds 2^(rows+cols) eight-byte words. The word offset is byte address bits [27:3] minus the socket base. For normal codes the column is the low `cols` bits of the offset and the row is the next `rows` bits.
- R2: Socket bases are the running sum of the sizes of the populated sockets with lower index. During an access exactly one RAS line is high: the one for the socket whose range holds the address.
- R3: When a start is accepted with an address at or above the total installed size, `out_of_range` is high for one cycle after that edge. No RAS line rises and the block stays idle.
- R4: In the cycle after an accepted start, `row_phase` is 1 and `ma` carries the row. From the following cycle on, `row_phase` is 0 and `ma` carries the column.
- R5: For a single-beat access (type 0 or 3), one `beat_adv` ends the access: `busy` and all RAS lines return to 0.
- R6: For a CPU burst (type 1), each `beat_adv` adds 1 modulo 4 to column bits [1:0] and leaves the higher column bits unchanged. `last_beat` is high on the fourth beat, and the fourth `beat_adv` ends the access.
- R7: For a PCI burst (type 2), each `beat_adv` adds 1 to the column. `burst_stop` ends any access in its column phase.
- R8: `page_end` is high in a PCI burst's column phase while the page bits of the column are all ones. The page is the column width, or 10 bits in mixed mode. A `beat_adv` at that point ends the access.
- R9: In mixed mode the row is {offset[10], offset[21:11]} and the column is {0, offset[10:0]}.
- R10: A refresh request seen while idle wins over a start in the same cycle. For one cycle `row_phase` is 1, `ma` holds the refresh counter and `ras_sel` holds the mask of populated sockets. The counter then increments, wrapping from REF_LAST to 0.
- R11: During reset `ma`, `ras_sel`, `row_phase`, `busy`, `last_beat`, `page_end` and `out_of_range` are 0, and the refresh counter restarts at 0.
- R12: A start seen while busy is ignored. The column, the RAS selection and the end of the current access are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| geom_cfg | input | NSOCK*4 | Geometry code per socket |
| start | input | 1 | Access request, taken while idle |
| xfer_type | input | 2 | 0 single, 1 CPU burst, 2 PCI burst, 3 single |
| addr | input | ADDR_W | Physical byte address |
| beat_adv | input | 1 | Current beat finished |
| burst_stop | input | 1 | End the current access |
| refresh_req | input | 1 | Refresh request |
| ma | output | 12 | Multiplexed memory address |
| row_phase | output | 1 | 1 while a row or refresh row is driven |
| ras_sel | output | NSOCK | RAS line per socket |
| busy | output | 1 | Access or refresh in progress |
| last_beat | output | 1 | Current beat ends the access |
| page_end | output | 1 | PCI column at the last column of its page |
| out_of_range | output | 1 | Start address beyond installed memory |

## Verification
The address split is exercised with a mix of sockets: an empty socket 0, a hole between populated sockets, and socket sizes of 4, 32 and 8 MB, one of them in mixed mode. The address vectors sit on the first and last word of several sockets, so an error in the base sum shows as a wrong RAS line. Vectors deep inside a socket give row and column values in which swapped or mis-shifted fields would differ. Addresses just past the installed total and at the very top of the space separate the out-of-range path from a wrap into socket 0. Bursts start at a column whose low bits wrap, and just below a page end in both normal and mixed mode. A separate run marks one empty socket with an unused code and confirms the ranges of the other sockets do not move.

// File: rtl/dram_amux_pkg.sv
package dram_amux_pkg;

  localparam int GEOM_W = 4;   // geometry code width per socket
  localparam int OFF_W  = 22;  // largest socket: 2^22 words
  localparam int MA_W   = 12;  // memory address lines
  localparam logic [GEOM_W-1:0] G_MIX = 4'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_ROW, ST_COL, ST_REF} amux_st_e;
  typedef enum logic [1:0] {XF_SINGLE, XF_CPU, XF_PCI} xfer_e;

  function automatic int geom_rows(input logic [GEOM_W-1:0] g);
    case (g)
      4'd1, 4'd4:             return 10;
      4'd2, 4'd5, 4'd7, 4'd8: return 11;
      4'd3, 4'd6:             return 12;
      default:                return 0;
    endcase
  endfunction

  function automatic int geom_cols(input logic [GEOM_W-1:0] g);
    case (g)
      4'd1, 4'd2, 4'd3: return 9;
      4'd4, 4'd5, 4'd6: return 10;
      4'd7, 4'd8:       return 11;
      default:          return 0;
    endcase
  endfunction

  function automatic logic geom_used(input logic [GEOM_W-1:0] g);
    return geom_rows(g) != 0;
  endfunction

  // log2 of socket size in words
  function automatic int geom_bits(input logic [GEOM_W-1:0] g);
    return geom_rows(g) + geom_cols(g);
  endfunction

  // width of the column field that stays inside one page
  function automatic int page_bits(input logic [GEOM_W-1:0] g);
    return (g == G_MIX) ? 10 : geom_cols(g);
  endfunction

  function automatic logic [MA_W-1:0] row_of(input logic [GEOM_W-1:0] g,
                                             input logic [OFF_W-1:0] off);
    logic [OFF_W-1:0] t;
    if (g == G_MIX) return {off[10], off[21:11]};
    t = off >> geom_cols(g);
    t = t & ~({OFF_W{1'b1}} << geom_rows(g));
    return t[MA_W-1:0];
  endfunction

  function automatic logic [MA_W-1:0] col_of(input logic [GEOM_W-1:0] g,
                                             input logic [OFF_W-1:0] off);
    logic [OFF_W-1:0] t;
    if (g == G_MIX) return {1'b0, off[10:0]};
    t = off & ~({OFF_W{1'b1}} << geom_cols(g));
    return t[MA_W-1:0];
  endfunction

endpackage

// File: rtl/dram_bank_decode.sv
module dram_bank_decode
  import dram_amux_pkg::*;
#(
  parameter int NSOCK = 8,
  parameter int WA_W  = 25
) (
  input  logic [NSOCK*GEOM_W-1:0] geom_cfg,
  input  logic [WA_W-1:0]         word_addr,
  output logic [NSOCK-1:0]        hit,
  output logic [NSOCK-1:0]        populated,
  output logic [OFF_W-1:0]        offset,
  output logic [GEOM_W-1:0]       code,
  output logic                    out_of_range
);
  localparam int SUM_W = WA_W + 1;

  logic [NSOCK:0][SUM_W-1:0] base;
  logic [SUM_W-1:0]          word_ext;
  logic [SUM_W-1:0]          off_full;

  assign word_ext = {1'b0, word_addr};
  assign base[0]  = '0;

  for (genvar gi = 0; gi < NSOCK; gi++) begin : g_sock
    logic [GEOM_W-1:0] g;
    logic [SUM_W-1:0]  sz;
    assign g             = geom_cfg[gi*GEOM_W +: GEOM_W];
    assign populated[gi] = geom_used(g);
    assign sz            = populated[gi] ? (SUM_W'(1) << geom_bits(g)) : '0;
    assign base[gi+1]    = base[gi] + sz;
    assign hit[gi]       = populated[gi] && (word_ext >= base[gi]) && (word_ext < base[gi+1]);
  end

  always_comb begin
    off_full = '0;
    code     = '0;
    for (int i = 0; i < NSOCK; i++) begin
      if (hit[i]) begin
        off_full = word_ext - base[i];
        code     = geom_cfg[i*GEOM_W +: GEOM_W];
      end
    end
  end

  assign offset       = off_full[OFF_W-1:0];
  assign out_of_range = ~|hit;

endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split
  import dram_amux_pkg::*;
(
  input  logic [GEOM_W-1:0] code,
  input  logic [OFF_W-1:0]  offset,
  output logic [MA_W-1:0]   row,
  output logic [MA_W-1:0]   col
);
  assign row = row_of(code, offset);
  assign col = col_of(code, offset);
endmodule

// File: rtl/dram_refresh_ctr.sv
module dram_refresh_ctr #(
  parameter int W        = 12,
  parameter int REF_LAST = 4095
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] LAST = W'(REF_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= (count == LAST) ? '0 : count + 1'b1;
  end

  // R10
  ref_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> count == (($past(count) == LAST) ? '0 : $past(count) + 1'b1));

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_amux_pkg::*;
#(
  parameter int NSOCK    = 8,
  parameter int ADDR_W   = 28,
  parameter int REF_LAST = 4095
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NSOCK*GEOM_W-1:0] geom_cfg,
  input  logic                    start,
  input  logic [1:0]              xfer_type,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    beat_adv,
  input  logic                    burst_stop,
  input  logic                    refresh_req,
  output logic [MA_W-1:0]         ma,
  output logic                    row_phase,
  output logic [NSOCK-1:0]        ras_sel,
  output logic                    busy,
  output logic                    last_beat,
  output logic                    page_end,
  output logic                    out_of_range
);
  localparam int WA_W     = ADDR_W - 3;
  localparam int BEAT_W   = 2;
  localparam logic [BEAT_W-1:0] CPU_LAST = '1;

  amux_st_e             st;
  xfer_e                xfer_q;
  logic [MA_W-1:0]      row_q, col_q;
  logic [NSOCK-1:0]     ras_q;
  logic [GEOM_W-1:0]    code_q;
  logic [BEAT_W-1:0]    beat_q;
  logic                 oor_q;

  logic [NSOCK-1:0]     dec_hit, dec_pop;
  logic [OFF_W-1:0]     dec_off;
  logic [GEOM_W-1:0]    dec_code;
  logic                 dec_oor;
  logic [MA_W-1:0]      split_row, split_col;
  logic [MA_W-1:0]      ref_cnt;

  // named events
  logic                 acc_accept, ref_accept, oor_hit, acc_done, ref_step;
  logic                 page_last;
  logic [MA_W-1:0]      page_mask, col_next;
  xfer_e                xfer_in;

  dram_bank_decode #(.NSOCK(NSOCK), .WA_W(WA_W)) u_dec (
    .geom_cfg(geom_cfg), .word_addr(addr[ADDR_W-1:3]), .hit(dec_hit),
    .populated(dec_pop), .offset(dec_off), .code(dec_code), .out_of_range(dec_oor)
  );

  dram_addr_split u_split (
    .code(dec_code), .offset(dec_off), .row(split_row), .col(split_col)
  );

  dram_refresh_ctr #(.W(MA_W), .REF_LAST(REF_LAST)) u_ref (
    .clk(clk), .rst_n(rst_n), .step(ref_step), .count(ref_cnt)
  );

  always_comb begin
    case (xfer_type)
      2'd1:    xfer_in = XF_CPU;
      2'd2:    xfer_in = XF_PCI;
      default: xfer_in = XF_SINGLE;
    endcase
  end

  assign ref_accept = (st == ST_IDLE) && refresh_req;
  assign acc_accept = (st == ST_IDLE) && !refresh_req && start && !dec_oor;
  assign oor_hit    = (st == ST_IDLE) && !refresh_req && start && dec_oor;
  assign ref_step   = (st == ST_REF);

  assign page_mask  = ~({MA_W{1'b1}} << page_bits(code_q));
  assign page_last  = (col_q & page_mask) == page_mask;
  assign page_end   = (st == ST_COL) && (xfer_q == XF_PCI) && page_last;

  always_comb begin
    last_beat = 1'b0;
    if (st == ST_COL) begin
      case (xfer_q)
        XF_CPU:  last_beat = (beat_q == CPU_LAST);
        XF_PCI:  last_beat = page_last;
        default: last_beat = 1'b1;
      endcase
    end
  end

  assign acc_done = (st == ST_COL) && (burst_stop || (beat_adv && last_beat));
  assign col_next = (xfer_q == XF_CPU) ? {col_q[MA_W-1:2], col_q[1:0] + 2'd1}
                                       : col_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      xfer_q <= XF_SINGLE;
      row_q  <= '0;
      col_q  <= '0;
      ras_q  <= '0;
      code_q <= '0;
      beat_q <= '0;
      oor_q  <= 1'b0;
    end else begin
      oor_q <= oor_hit;
      case (st)
        ST_IDLE: begin
          if (ref_accept) st <= ST_REF;
          else if (acc_accept) begin
            st     <= ST_ROW;
            row_q  <= split_row;
            col_q  <= split_col;
            ras_q  <= dec_hit;
            code_q <= dec_code;
            xfer_q <= xfer_in;
            beat_q <= '0;
          end
        end
        ST_ROW: st <= ST_COL;
        ST_COL: begin
          if (acc_done) begin
            st    <= ST_IDLE;
            ras_q <= '0;
          end else if (beat_adv) begin
            beat_q <= beat_q + 1'b1;
            col_q  <= col_next;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_ROW:  ma = row_q;
      ST_COL:  ma = col_q;
      ST_REF:  ma = ref_cnt;
      default: ma = '0;
    endcase
  end

  assign row_phase    = (st == ST_ROW) || (st == ST_REF);
  assign ras_sel      = (st == ST_REF) ? dec_pop :
                        ((st == ST_ROW) || (st == ST_COL)) ? ras_q : '0;
  assign busy         = (st != ST_IDLE);
  assign out_of_range = oor_q;

  // R2
  ras_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ROW) || (st == ST_COL)) |-> $onehot(ras_sel));

  // R3
  oor_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_of_range |-> (ras_sel == '0) && !busy);

  // R4
  row_then_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ROW) |=> (st == ST_COL) && !row_phase);

  // R6
  cpu_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_COL) && (xfer_q == XF_CPU) && beat_adv && !burst_stop && (beat_q != CPU_LAST))
    |=> (col_q[1:0] == $past(col_q[1:0]) + 2'd1) && (col_q[MA_W-1:2] == $past(col_q[MA_W-1:2])));

  // R7
  pci_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_COL) && (xfer_q == XF_PCI) && beat_adv && !burst_stop && !page_end)
    |=> col_q == $past(col_q) + 1'b1);

  // R8
  page_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_end && beat_adv) |=> !busy);

  // R10
  ref_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_IDLE) && refresh_req) |=> (st == ST_REF) && row_phase);

  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_COL) && !beat_adv && !burst_stop) |=> $stable(col_q) && $stable(ras_q));

endmodule

// File: tb/dram_addr_mux_test.sv
`timescale 1ns/1ps
module dram_addr_mux_test;
  localparam int TB_REF_LAST = 5;
  localparam int NV = 12;
  localparam logic [7:0] POP_MASK = 8'b1011_1010;
  localparam logic [31:0] GEOM_A = {4'd2, 4'd0, 4'd7, 4'd8, 4'd6, 4'd0, 4'd1, 4'd0};

  localparam logic [27:0] VEC_ADDR [NV] = '{
    28'h000_0000, 28'h03F_FFF8, 28'h040_0000, 28'h23F_FFF8,
    28'h241_2348, 28'h3AB_CDE8, 28'h440_0008, 28'h555_5550,
    28'h640_0010, 28'h6BF_FFF8, 28'h6C0_0000, 28'hFFF_FFF8};
  localparam int VEC_SOCK [NV] = '{1, 1, 3, 3, 4, 4, 5, 5, 7, 7, -1, -1};

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] geom_cfg = GEOM_A;
  logic        start = 0, beat_adv = 0, burst_stop = 0, refresh_req = 0;
  logic [1:0]  xfer_type = 0;
  logic [27:0] addr = 0;
  logic [11:0] ma;
  logic        row_phase, busy, last_beat, page_end, out_of_range;
  logic [7:0]  ras_sel;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dram_addr_mux #(.NSOCK(8), .ADDR_W(28), .REF_LAST(TB_REF_LAST)) uut (
    .clk(clk), .rst_n(rst_n), .geom_cfg(geom_cfg), .start(start),
    .xfer_type(xfer_type), .addr(addr), .beat_adv(beat_adv),
    .burst_stop(burst_stop), .refresh_req(refresh_req), .ma(ma),
    .row_phase(row_phase), .ras_sel(ras_sel), .busy(busy),
    .last_beat(last_beat), .page_end(page_end), .out_of_range(out_of_range));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int b_rows(input int c);
    if (c == 1 || c == 4) return 10;
    if (c == 3 || c == 6) return 12;
    if (c == 2 || c == 5 || c == 7 || c == 8) return 11;
    return 0;
  endfunction

  function automatic int b_cols(input int c);
    if (c >= 1 && c <= 3) return 9;
    if (c >= 4 && c <= 6) return 10;
    if (c == 7 || c == 8) return 11;
    return 0;
  endfunction

  // independent model: walk the sockets, then divide the offset
  function automatic void model(input logic [27:0] a, input logic [31:0] cfg,
                                output int sock, output int row, output int col);
    int word, acc, sz, off, code, hitc;
    word = int'(a >> 3); acc = 0; sock = -1; off = 0; hitc = 0;
    for (int s = 0; s < 8; s++) begin
      code = int'(cfg[s*4 +: 4]);
      sz = (b_rows(code) != 0) ? (1 << (b_rows(code) + b_cols(code))) : 0;
      if (sock < 0 && word >= acc && word < acc + sz) begin
        sock = s; off = word - acc; hitc = code;
      end
      acc += sz;
    end
    if (hitc == 8) begin
      col = off % 2048;
      row = ((off / 2048) % 2048) + (((off / 1024) % 2) * 2048);
    end else if (hitc != 0) begin
      col = off % (1 << b_cols(hitc));
      row = off / (1 << b_cols(hitc));
    end else begin
      row = 0; col = 0;
    end
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic issue(input logic [27:0] a, input logic [1:0] t);
    addr = a; xfer_type = t; start = 1;
    tick();
    start = 0;
  endtask

  task automatic beat();
    beat_adv = 1;
    tick();
    beat_adv = 0;
  endtask

  task automatic run_vec(input logic [27:0] a, input int exp_sock);
    int s, r, c;
    model(a, geom_cfg, s, r, c);
    issue(a, 2'd0);
    if (exp_sock < 0) begin
      chk("R3 out_of_range", 32'(out_of_range), 1);
      chk("R3 no ras", 32'(ras_sel), 0);
      chk("R3 idle", 32'(busy), 0);
      tick();
      chk("R3 pulse one cycle", 32'(out_of_range), 0);
    end else begin
      chk("R4 row phase", 32'(row_phase), 1);
      chk(s == 4 ? "R9 row" : "R1 row", 32'(ma), 32'(r));
      chk("R2 ras", 32'(ras_sel), 32'(1) << exp_sock);
      chk("R2 model sock", 32'(s), 32'(exp_sock));
      tick();
      chk("R4 col phase", 32'(row_phase), 0);
      chk(s == 4 ? "R9 col" : "R1 col", 32'(ma), 32'(c));
      chk("R5 last_beat single", 32'(last_beat), 1);
      beat();
      chk("R5 done busy", 32'(busy), 0);
      chk("R5 done ras", 32'(ras_sel), 0);
    end
  endtask

  initial begin
    repeat (3) tick();
    // R11 reset state
    chk("R11 ma", 32'(ma), 0);
    chk("R11 ras", 32'(ras_sel), 0);
    chk("R11 row_phase", 32'(row_phase), 0);
    chk("R11 busy", 32'(busy), 0);
    chk("R11 flags", {29'd0, last_beat, page_end, out_of_range}, 0);
    rst_n = 1;
    tick();

    for (int k = 0; k < NV; k++) run_vec(VEC_ADDR[k], VEC_SOCK[k]);

    // R1 unused code counts as empty: socket 6 = 15
    geom_cfg = {4'd2, 4'd15, 4'd7, 4'd8, 4'd6, 4'd0, 4'd1, 4'd0};
    run_vec(28'h640_0010, 7);
    geom_cfg = GEOM_A;

    // R6 CPU burst, column 1014 in socket 3
    issue(28'h040_1FB0, 2'd1);
    tick();
    chk("R6 col0", 32'(ma), 1014);
    beat(); chk("R6 col1", 32'(ma), 1015);
    beat(); chk("R6 col2 wrap", 32'(ma), 1012);
    chk("R6 not last", 32'(last_beat), 0);
    beat(); chk("R6 col3", 32'(ma), 1013);
    chk("R6 last_beat", 32'(last_beat), 1);
    beat(); chk("R6 end", 32'(busy), 0);

    // R8 PCI to page end, socket 1 column 509
    issue(28'h000_0FE8, 2'd2);
    tick();
    chk("R8 col509", 32'(ma), 509);
    chk("R8 no page_end", 32'(page_end), 0);
    beat(); chk("R7 col510", 32'(ma), 510);
    beat(); chk("R7 col511", 32'(ma), 511);
    chk("R8 page_end", 32'(page_end), 1);
    beat(); chk("R8 stop at page end", 32'(busy), 0);

    // R8 R9 mixed mode page is 10 bits
    issue(28'h240_1FF0, 2'd2);
    tick();
    chk("R9 col1022", 32'(ma), 1022);
    beat(); chk("R9 col1023", 32'(ma), 1023);
    chk("R8 mixed page_end", 32'(page_end), 1);
    beat(); chk("R8 mixed stop", 32'(busy), 0);

    // R7 burst_stop, socket 5 word 1
    issue(28'h440_0008, 2'd2);
    tick();
    beat(); chk("R7 step", 32'(ma), 2);
    burst_stop = 1; tick(); burst_stop = 0;
    chk("R7 burst_stop ends", 32'(busy), 0);

    // R12 start while busy ignored
    issue(28'h040_0000, 2'd0);
    tick();
    addr = 28'h640_0010; start = 1; tick(); start = 0;
    chk("R12 col kept", 32'(ma), 0);
    chk("R12 ras kept", 32'(ras_sel), 32'h08);
    chk("R12 still busy", 32'(busy), 1);
    beat(); chk("R12 ends normally", 32'(busy), 0);

    // R10 refresh counter and wrap
    for (int n = 0; n <= TB_REF_LAST + 1; n++) begin
      refresh_req = 1; tick(); refresh_req = 0;
      chk("R10 ref row", 32'(ma), 32'(n % (TB_REF_LAST + 1)));
      chk("R10 ref phase", 32'(row_phase), 1);
      chk("R10 ref ras", 32'(ras_sel), 32'(POP_MASK));
      tick();
      chk("R10 ref one cycle", 32'(busy), 0);
    end

    // R10 priority over start
    addr = 28'h040_0000; start = 1; refresh_req = 1; tick();
    start = 0; refresh_req = 0;
    chk("R10 prio ma", 32'(ma), 1);
    chk("R10 prio ras", 32'(ras_sel), 32'(POP_MASK));
    tick();
    chk("R10 start dropped", 32'(busy), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule